// File: doc/BRIEF.md
# Host Bus Chip-Select Sequencer

This block runs one access at a time from an on-chip request port out to parallel memories or peripherals on an external host bus. It drives a set of five registered strobe pins, active-low read and write strobes, a held address and a write-data bus with its own output enable. A three-bit pin-role code sets the job of each strobe pin. The shared pin 0 serves either as an address-latch pulse or as a chip select. The code also sets how many active-low chip selects exist: none, one, two or four. Region enables and a code-space flag decide which chip select an address reaches.

The request port uses valid/ready. The requester raises `req_valid` and holds `req_we`, `req_addr` and `req_wdata` steady until it sees `req_ready` high on a rising edge. `req_ready` is high in exactly one clock per access: the last data-phase clock, or the single error clock. In that same clock `rsp_err` and `rsp_rdata` are valid. The block applies back-pressure by keeping `req_ready` low through the address phase and every wait state. The configuration inputs must stay constant while an access is in progress.

Address map: `req_addr[AW-1:AW-2]` names the region. 0 is the code region, 1 the peripheral region, 2 the memory region and 3 is never mapped. Below the region bits, `req_addr[AW-3]` is the local top bit and `req_addr[AW-3:AW-4]` are the local top two bits.

Top module: `hbus_strobe_seq`

## Requirements
- R1: Pin roles by `cfg_pin_role`: 0 = pin0 latch only; 1 = pin0 CS0; 2 = pin0 CS0, pin1 CS1; 3 = pin0 latch, pin1 CS1, pin2 CS0; 4 = pin0 latch, pin1 CS0; 5 = pin0 CS0, pin1 CS1, pin3 CS2, pin4 CS3; 6 = pin0 latch, pin1 CS1, pin2 CS0, pin3 CS2, pin4 CS3. An idle latch pin is 0, an idle chip select is 1, and an unused pin is 1. In role 1 and role 4 every enabled-region access uses CS0. At most one chip select is low at any time.
- R2: The address phase is one clock after the accepting edge. In it the latch pin is 1 (latch roles only), the selected chip select is low, both strobes are high, and `bus_addr` equals the request address.
- R3: The data phase lasts 1 + wait − trim clocks, and never fewer than 1. Reads use `cfg_rd_wait`/`cfg_rd_trim` and writes use `cfg_wr_wait`/`cfg_wr_trim`. The chip select stays low throughout.
- R4: `bus_rd_n` is low only in read data phases and `bus_wr_n` only in write data phases; the two are never low together. `bus_dout_en` is high in write data phases with `bus_dout` equal to the write data. In the ready clock of a read, `rsp_rdata` equals `bus_din`.
- R5: `req_ready` is high for exactly one clock, the last data-phase clock, with `rsp_err` low.
- R6: After the data phase comes one release clock in which every pin is at its idle value and both strobes are high.
- R7: In roles 2 and 3, when only one region is enabled, the local top bit picks the chip select: 0 gives CS0 and 1 gives CS1.
- R8: In roles 2 and 3, with the code flag clear and both the peripheral and memory regions enabled, peripheral accesses use CS0 and memory accesses use CS1.
- R9: In roles 2 and 3, with the code flag set and the peripheral or memory region enabled, code accesses use CS0 and the other enabled region uses CS1.
- R10: In roles 5 and 6, the local top two bits give the index of the chip select (0 to 3).
- R11: Role 7, or an address in a disabled or unmapped region, produces one clock with `req_ready` and `rsp_err` high and no strobe, latch pulse or chip select.
- R12: From the first clock after reset, the pins show the idle values of R1, both strobes are high and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pin_role | input | 3 | Strobe pin role code (R1) |
| cfg_periph_en | input | 1 | Peripheral region enabled |
| cfg_mem_en | input | 1 | Memory region enabled |
| cfg_code_en | input | 1 | Code region flag |
| cfg_rd_wait | input | WW | Read wait states |
| cfg_wr_wait | input | WW | Write wait states |
| cfg_rd_trim | input | 1 | Trim one read wait state |
| cfg_wr_trim | input | 1 | Trim one write wait state |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted / response valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data |
| rsp_err | output | 1 | Error response |
| bus_pins | output | 5 | Strobe pins (latch / chip selects) |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | Write data to the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DW | Read data from the bus |

## Verification
The address-phase pins are due one clock after the edge that sees `req_valid` in idle. The data-phase strobes are due on the next L clocks, where L = 1 + wait − trim (at least 1). `req_ready` is due on the last of those L clocks, the release on clock L+2 and idle on clock L+3. An error is due on the first clock and idle on the second. The bench computes L, the decoded chip select and the expected pin vector per access. It samples on every falling edge from clock 1 to clock L+3, so each result is compared on the exact clock it is due and never on a neighbouring one. Configuration changes are followed by two idle clocks before the idle pins are compared.

// File: rtl/hbus_seq_pkg.sv
package hbus_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_REL  = 3'd3,
    PH_ERR  = 3'd4
  } phase_t;

  localparam int NUM_CS   = 4;
  localparam int NUM_PINS = 5;
endpackage

// File: rtl/hbus_cs_decode.sv
module hbus_cs_decode #(
  parameter int AW = 16
) (
  input  logic [2:0]    pin_role,
  input  logic          periph_en,
  input  logic          mem_en,
  input  logic          code_en,
  input  logic [AW-1:0] addr,
  output logic          dec_err,
  output logic          dec_ale,
  output logic [3:0]    dec_cs
);
  logic [1:0] region;
  logic [1:0] local_top;
  logic       region_on;
  logic [2:0] n_cs;
  logic [1:0] sel;

  assign region    = addr[AW-1:AW-2];
  assign local_top = addr[AW-3:AW-4];

  always_comb begin
    unique case (region)
      2'd0:    region_on = code_en;
      2'd1:    region_on = periph_en;
      2'd2:    region_on = mem_en;
      default: region_on = 1'b0;
    endcase
  end

  always_comb begin
    n_cs    = 3'd0;
    dec_ale = 1'b0;
    unique case (pin_role)
      3'd0: begin n_cs = 3'd0; dec_ale = 1'b1; end
      3'd1: begin n_cs = 3'd1; end
      3'd2: begin n_cs = 3'd2; end
      3'd3: begin n_cs = 3'd2; dec_ale = 1'b1; end
      3'd4: begin n_cs = 3'd1; dec_ale = 1'b1; end
      3'd5: begin n_cs = 3'd4; end
      3'd6: begin n_cs = 3'd4; dec_ale = 1'b1; end
      default: begin n_cs = 3'd0; end
    endcase
  end

  always_comb begin
    sel = 2'd0;
    if (n_cs == 3'd4) begin
      sel = local_top;
    end else if (n_cs == 3'd2) begin
      if (code_en && (periph_en || mem_en))
        sel = (region == 2'd0) ? 2'd0 : 2'd1;
      else if (!code_en && periph_en && mem_en)
        sel = (region == 2'd1) ? 2'd0 : 2'd1;
      else
        sel = {1'b0, local_top[1]};
    end
  end

  assign dec_err = (pin_role == 3'd7) || !region_on;

  for (genvar gi = 0; gi < 4; gi++) begin : g_cs
    assign dec_cs[gi] = (n_cs != 3'd0) && (sel == gi[1:0]);
  end
endmodule

// File: rtl/hbus_phase_ctrl.sv
module hbus_phase_ctrl
  import hbus_seq_pkg::*;
#(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          dec_err,
  input  logic [WW-1:0] rd_wait,
  input  logic [WW-1:0] wr_wait,
  input  logic          rd_trim,
  input  logic          wr_trim,
  output phase_t        phase_q,
  output phase_t        phase_nxt,
  output logic          ready
);
  logic [WW-1:0] cnt_q;
  logic [WW-1:0] wait_sel;
  logic          trim_sel;
  logic [WW-1:0] cnt_init;

  assign wait_sel = req_we ? wr_wait : rd_wait;
  assign trim_sel = req_we ? wr_trim : rd_trim;
  assign cnt_init = (trim_sel && wait_sel != '0) ? wait_sel - 1'b1 : wait_sel;

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_valid) phase_nxt = dec_err ? PH_ERR : PH_ADDR;
      PH_ADDR: phase_nxt = PH_DATA;
      PH_DATA: if (cnt_q == '0) phase_nxt = PH_REL;
      PH_REL:  phase_nxt = PH_IDLE;
      PH_ERR:  phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_nxt;
      if (phase_q == PH_IDLE && req_valid)
        cnt_q <= cnt_init;
      else if (phase_q == PH_DATA && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = (phase_q == PH_DATA && cnt_q == '0) || (phase_q == PH_ERR);
endmodule

// File: rtl/hbus_pin_map.sv
module hbus_pin_map
  import hbus_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          pin_role,
  input  logic                ale_d,
  input  logic [NUM_CS-1:0]   csn_d,
  output logic [NUM_PINS-1:0] pins_q
);
  logic [NUM_PINS-1:0] pins_d;

  always_comb begin
    unique case (pin_role)
      3'd0:    pins_d = {1'b1, 1'b1, 1'b1, 1'b1, ale_d};
      3'd1:    pins_d = {1'b1, 1'b1, 1'b1, 1'b1, csn_d[0]};
      3'd2:    pins_d = {1'b1, 1'b1, 1'b1, csn_d[1], csn_d[0]};
      3'd3:    pins_d = {1'b1, 1'b1, csn_d[0], csn_d[1], ale_d};
      3'd4:    pins_d = {1'b1, 1'b1, 1'b1, csn_d[0], ale_d};
      3'd5:    pins_d = {csn_d[3], csn_d[2], 1'b1, csn_d[1], csn_d[0]};
      3'd6:    pins_d = {csn_d[3], csn_d[2], csn_d[0], csn_d[1], ale_d};
      default: pins_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '1;
    else        pins_q <= pins_d;
  end
endmodule

// File: rtl/hbus_strobe_seq.sv
module hbus_strobe_seq
  import hbus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_pin_role,
  input  logic          cfg_periph_en,
  input  logic          cfg_mem_en,
  input  logic          cfg_code_en,
  input  logic [WW-1:0] cfg_rd_wait,
  input  logic [WW-1:0] cfg_wr_wait,
  input  logic          cfg_rd_trim,
  input  logic          cfg_wr_trim,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [4:0]    bus_pins,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  input  logic [DW-1:0] bus_din
);
  phase_t            phase_q, phase_nxt;
  logic              dec_err, dec_ale;
  logic [NUM_CS-1:0] dec_cs;
  logic              acc_ale_q, acc_we_q;
  logic [NUM_CS-1:0] acc_cs_q;
  logic              ale_n, we_n;
  logic [NUM_CS-1:0] cs_n;
  logic              ale_d, rd_n_d, wr_n_d, den_d;
  logic [NUM_CS-1:0] csn_d;
  logic              ale_q;
  logic [NUM_CS-1:0] csn_q;
  logic              rd_n_q, wr_n_q, den_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     dout_q;
  logic              take;
  logic              sel_on;

  hbus_cs_decode #(.AW(AW)) u_dec (
    .pin_role  (cfg_pin_role),
    .periph_en (cfg_periph_en),
    .mem_en    (cfg_mem_en),
    .code_en   (cfg_code_en),
    .addr      (req_addr),
    .dec_err   (dec_err),
    .dec_ale   (dec_ale),
    .dec_cs    (dec_cs)
  );

  hbus_phase_ctrl #(.WW(WW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .dec_err   (dec_err),
    .rd_wait   (cfg_rd_wait),
    .wr_wait   (cfg_wr_wait),
    .rd_trim   (cfg_rd_trim),
    .wr_trim   (cfg_wr_trim),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .ready     (req_ready)
  );

  // Decoded values feed the first clock; the latched copy feeds the rest.
  assign take  = (phase_q == PH_IDLE) && req_valid && !dec_err;
  assign ale_n = (phase_q == PH_IDLE) ? dec_ale : acc_ale_q;
  assign cs_n  = (phase_q == PH_IDLE) ? dec_cs  : acc_cs_q;
  assign we_n  = (phase_q == PH_IDLE) ? req_we  : acc_we_q;

  assign sel_on = (phase_nxt == PH_ADDR) || (phase_nxt == PH_DATA);
  assign ale_d  = (phase_nxt == PH_ADDR) && ale_n;
  assign csn_d  = ~({NUM_CS{sel_on}} & cs_n);
  assign rd_n_d = !((phase_nxt == PH_DATA) && !we_n);
  assign wr_n_d = !((phase_nxt == PH_DATA) && we_n);
  assign den_d  = (phase_nxt == PH_DATA) && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ale_q <= 1'b0;
      acc_we_q  <= 1'b0;
      acc_cs_q  <= '0;
      addr_q    <= '0;
      dout_q    <= '0;
    end else if (take) begin
      acc_ale_q <= dec_ale;
      acc_we_q  <= req_we;
      acc_cs_q  <= dec_cs;
      addr_q    <= req_addr;
      dout_q    <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      csn_q  <= '1;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      den_q  <= 1'b0;
    end else begin
      ale_q  <= ale_d;
      csn_q  <= csn_d;
      rd_n_q <= rd_n_d;
      wr_n_q <= wr_n_d;
      den_q  <= den_d;
    end
  end

  hbus_pin_map u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_role (cfg_pin_role),
    .ale_d    (ale_d),
    .csn_d    (csn_d),
    .pins_q   (bus_pins)
  );

  assign bus_rd_n    = rd_n_q;
  assign bus_wr_n    = wr_n_q;
  assign bus_dout_en = den_q;
  assign bus_addr    = addr_q;
  assign bus_dout    = dout_q;
  assign rsp_rdata   = bus_din;
  assign rsp_err     = (phase_q == PH_ERR);
endmodule

// File: rtl/hbus_strobe_seq_chk.sv
module hbus_strobe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_err,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       ale_q,
  input logic [3:0] csn_q
);
  // R4: read and write strobes never active together
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R1: at most one chip select low
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~csn_q));

  // R5: a good response comes only while a strobe is active
  p_ready_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !rsp_err) |-> (!bus_rd_n || !bus_wr_n));

  // R5: ready lasts a single clock
  p_ready_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R6: a strobe release is followed by a clock with both strobes still high
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |=> (bus_rd_n && bus_wr_n));

  // R11: error clock carries no strobe, latch pulse or chip select
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (bus_rd_n && bus_wr_n && !ale_q && (&csn_q) && req_ready));

  // R2: latch pulse never overlaps a strobe
  p_ale_before_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_q |-> (bus_rd_n && bus_wr_n));
endmodule

bind hbus_strobe_seq hbus_strobe_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_err   (rsp_err),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .ale_q     (ale_q),
  .csn_q     (csn_q)
);

// File: tb/test_hbus_strobe_seq.sv
`timescale 1ns/1ps
module test_hbus_strobe_seq;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cfg_pin_role = 3'd0;
  logic          cfg_periph_en = 1'b0, cfg_mem_en = 1'b0, cfg_code_en = 1'b0;
  logic [WW-1:0] cfg_rd_wait = '0, cfg_wr_wait = '0;
  logic          cfg_rd_trim = 1'b0, cfg_wr_trim = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic          req_ready, rsp_err;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, rsp_rdata, bus_dout, bus_din = '0;
  logic [4:0]    bus_pins;
  logic          bus_rd_n, bus_wr_n, bus_dout_en;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbus_strobe_seq #(.AW(AW), .DW(DW), .WW(WW)) i_hbus_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cfg_pin_role(cfg_pin_role),
    .cfg_periph_en(cfg_periph_en), .cfg_mem_en(cfg_mem_en), .cfg_code_en(cfg_code_en),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
    .cfg_rd_trim(cfg_rd_trim), .cfg_wr_trim(cfg_wr_trim),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .bus_pins(bus_pins), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Pin vector from the R1 role table; cs is active high here.
  function automatic logic [4:0] exp_pins(input logic [2:0] role, input logic ale, input logic [3:0] cs);
    logic [4:0] p;
    p = 5'b11111;
    case (role)
      3'd0: p[0] = ale;
      3'd1: p[0] = ~cs[0];
      3'd2: begin p[0] = ~cs[0]; p[1] = ~cs[1]; end
      3'd3: begin p[0] = ale; p[1] = ~cs[1]; p[2] = ~cs[0]; end
      3'd4: begin p[0] = ale; p[1] = ~cs[0]; end
      3'd5: begin p[0] = ~cs[0]; p[1] = ~cs[1]; p[3] = ~cs[2]; p[4] = ~cs[3]; end
      3'd6: begin p[0] = ale; p[1] = ~cs[1]; p[2] = ~cs[0]; p[3] = ~cs[2]; p[4] = ~cs[3]; end
      default: p = 5'b11111;
    endcase
    return p;
  endfunction

  // Returns {err, ale, cs[3:0]} from R1, R7-R11.
  function automatic logic [5:0] exp_dec(input logic [2:0] role, input logic p, input logic m,
                                         input logic c, input logic [AW-1:0] a);
    logic [1:0] rg;
    logic on, ale;
    logic [3:0] cs;
    int idx;
    rg = a[AW-1:AW-2];
    on = (rg == 2'd0) ? c : (rg == 2'd1) ? p : (rg == 2'd2) ? m : 1'b0;
    if (role == 3'd7 || !on) return 6'b100000;
    ale = (role == 3'd0) || (role == 3'd3) || (role == 3'd4) || (role == 3'd6);
    cs = 4'b0000;
    if (role == 3'd1 || role == 3'd4) cs = 4'b0001;
    else if (role == 3'd2 || role == 3'd3) begin
      if (c && (p || m)) idx = (rg == 2'd0) ? 0 : 1;
      else if (p && m)   idx = (rg == 2'd1) ? 0 : 1;
      else               idx = int'(a[AW-3]);
      cs[idx] = 1'b1;
    end else if (role == 3'd5 || role == 3'd6) begin
      idx = int'(a[AW-3:AW-4]);
      cs[idx] = 1'b1;
    end
    return {1'b0, ale, cs};
  endfunction

  function automatic string sel_tag(input logic [2:0] role, input logic p, input logic m, input logic c);
    if (role == 3'd2 || role == 3'd3) begin
      if (c && (p || m)) return "R9";
      if (p && m) return "R8";
      return "R7";
    end
    if (role == 3'd5 || role == 3'd6) return "R10";
    return "R1";
  endfunction

  task automatic set_cfg(input logic [2:0] role, input logic p, input logic m, input logic c,
                         input int rw, input int ww, input bit rt, input bit wt);
    @(negedge clk);
    cfg_pin_role = role; cfg_periph_en = p; cfg_mem_en = m; cfg_code_en = c;
    cfg_rd_wait = WW'(rw); cfg_wr_wait = WW'(ww); cfg_rd_trim = rt; cfg_wr_trim = wt;
    repeat (2) @(negedge clk);
    chk(bus_pins == exp_pins(role, 1'b0, 4'b0), "R1 idle pins", 32'(bus_pins), 32'(exp_pins(role, 1'b0, 4'b0)));
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [DW-1:0] din);
    logic [5:0] d;
    logic [4:0] idle_p, ep;
    int L, w, t;
    string stag;
    d = exp_dec(cfg_pin_role, cfg_periph_en, cfg_mem_en, cfg_code_en, a);
    stag = sel_tag(cfg_pin_role, cfg_periph_en, cfg_mem_en, cfg_code_en);
    idle_p = exp_pins(cfg_pin_role, 1'b0, 4'b0);
    w = we ? int'(cfg_wr_wait) : int'(cfg_rd_wait);
    t = we ? int'(cfg_wr_trim) : int'(cfg_rd_trim);
    L = 1 + w - t;
    if (L < 1) L = 1;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; bus_din = din;
    if (d[5]) begin
      @(negedge clk);
      chk(req_ready && rsp_err, "R11 error response", {30'b0, req_ready, rsp_err}, 32'h3);
      chk(bus_pins == idle_p && bus_rd_n && bus_wr_n, "R11 no strobes",
          {25'b0, bus_pins, bus_rd_n, bus_wr_n}, {25'b0, idle_p, 2'b11});
      req_valid = 1'b0;
      @(negedge clk);
      chk(!req_ready && !rsp_err, "R11 single clock", {30'b0, req_ready, rsp_err}, 32'h0);
      return;
    end
    for (int k = 1; k <= L + 3; k++) begin
      @(negedge clk);
      if (k == 1) begin
        ep = exp_pins(cfg_pin_role, d[4], d[3:0]);
        chk(bus_pins == ep, {stag, " R2 address phase pins"}, 32'(bus_pins), 32'(ep));
        chk(bus_rd_n && bus_wr_n && !req_ready && bus_addr == a, "R2 strobes/address",
            {bus_addr, 13'b0, bus_rd_n, bus_wr_n, req_ready}, {a, 13'b0, 3'b110});
      end else if (k <= L + 1) begin
        ep = exp_pins(cfg_pin_role, 1'b0, d[3:0]);
        chk(bus_pins == ep, {stag, " R3 data phase pins"}, 32'(bus_pins), 32'(ep));
        chk(bus_rd_n == we && bus_wr_n == !we && bus_dout_en == we, "R4 strobe direction",
            {29'b0, bus_rd_n, bus_wr_n, bus_dout_en}, {29'b0, we, !we, we});
        chk(req_ready == (k == L + 1) && !rsp_err, "R5 ready timing",
            {30'b0, req_ready, rsp_err}, {30'b0, k == L + 1, 1'b0});
        if (we) chk(bus_dout == wd, "R4 write data", 32'(bus_dout), 32'(wd));
        if (!we && k == L + 1) chk(rsp_rdata == din, "R4 read data", 32'(rsp_rdata), 32'(din));
        if (k == L + 1) req_valid = 1'b0;
      end else begin
        chk(bus_pins == idle_p && bus_rd_n && bus_wr_n && !req_ready && !bus_dout_en, "R6 release/idle",
            {24'b0, bus_pins, bus_rd_n, bus_wr_n, req_ready}, {24'b0, idle_p, 3'b110});
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12: reset state, role 0 idle
    chk(bus_pins == 5'b11110 && bus_rd_n && bus_wr_n && !req_ready, "R12 reset state",
        {27'b0, bus_pins}, 32'h1e);

    // R1: every role's idle pins and a plain access
    for (int r = 0; r < 7; r++) begin
      set_cfg(3'(r), 1'b1, 1'b0, 1'b0, 1, 2, 1'b0, 1'b0);
      access(1'b0, 16'h4000, 8'h00, 8'hA5);
      access(1'b1, 16'h4000, 8'h3C, 8'h00);
    end
    // R7: dual CS, peripheral only; local top bit picks
    set_cfg(3'd2, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    access(1'b0, 16'h4000, 8'h00, 8'h11);
    access(1'b1, 16'h6000, 8'h22, 8'h00);
    // R8: dual CS with latch, both regions, code clear
    set_cfg(3'd3, 1'b1, 1'b1, 1'b0, 2, 1, 1'b0, 1'b0);
    access(1'b0, 16'h6000, 8'h00, 8'h33);
    access(1'b1, 16'h8000, 8'h44, 8'h00);
    // R9: code flag with memory region
    set_cfg(3'd2, 1'b0, 1'b1, 1'b1, 1, 1, 1'b0, 1'b0);
    access(1'b0, 16'h2000, 8'h00, 8'h55);
    access(1'b0, 16'h8000, 8'h00, 8'h66);
    // R10: quad CS, each index
    set_cfg(3'd6, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) access(1'b1, 16'h8000 | 16'(i << 12), 8'(i), 8'h00);
    // R3: trim at zero wait and at nonzero wait
    set_cfg(3'd5, 1'b1, 1'b0, 1'b0, 0, 3, 1'b1, 1'b1);
    access(1'b0, 16'h5000, 8'h00, 8'h77);
    access(1'b1, 16'h7000, 8'h88, 8'h00);
    set_cfg(3'd4, 1'b1, 1'b0, 1'b0, 15, 15, 1'b0, 1'b1);
    access(1'b0, 16'h4000, 8'h00, 8'h99);
    access(1'b1, 16'h4000, 8'hAA, 8'h00);
    // R11: reserved role, disabled region, unmapped region
    set_cfg(3'd7, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0, 1'b0);
    access(1'b0, 16'h4000, 8'h00, 8'h00);
    set_cfg(3'd2, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    access(1'b1, 16'h8000, 8'h01, 8'h00);
    access(1'b0, 16'hC000, 8'h00, 8'h00);

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      if (n % 6 == 0)
        set_cfg(3'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 16), int'($urandom % 16), 1'($urandom), 1'($urandom));
      access(1'($urandom), AW'($urandom), DW'($urandom), DW'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule